// File: doc/BRIEF.md
# Predicated Execution Condition Unit

This unit sits beside the decode stage of a small 32-bit core whose instructions all carry a 3-bit condition query. It keeps the 3-bit comparison result that decides which of those instructions run. For every presented instruction it reports, in the same cycle, whether the instruction may execute. The test is a bitwise AND of the query against the stored result, and the instruction runs when that AND is nonzero.

A compare instruction runs a signed comparison. Operand A is a full 32-bit register value. Operand B is a 20-bit register-or-immediate field that the unit sign-extends itself. The one-hot outcome is written into the comparison register at the clock edge that ends the instruction, and only when that compare is allowed to execute. Out of reset the register holds the all-ones "always" pattern, so every nonzero query passes until the first compare. That pattern can never come back after the first compare.

Top module: `pred_cond_unit`

## Requirements
- R1: While and just after synchronous reset, `cmp_state` reads 3'b111.
- R2: When `instr_valid` is 1, `exec_en` equals 1 exactly when `cond_query & cmp_state` is nonzero. It depends only on the current inputs and the current `cmp_state`, within the same cycle.
- R3: When `instr_valid` is 0, `exec_en` is 0 for every query, whatever the register holds.
- R4: Query 3'b000 never gives `exec_en` = 1.
- R5: Before the first executed compare, every nonzero query gives `exec_en` = 1 when `instr_valid` is 1.
- R6: A compare that executes writes a one-hot result into `cmp_state` at the next rising edge. Bit 2 means A is less than B, bit 1 means A equals B, and bit 0 means A is greater than B.
- R7: The compare is signed on 32 bits. B is `cmp_opnd_b` sign-extended from 20 bits, using bit 19 as the sign.
- R8: A compare whose own query fails leaves `cmp_state` unchanged.
- R9: An instruction that is not a compare, or a compare with `instr_valid` at 0, leaves `cmp_state` unchanged.
- R10: Once any compare has executed, `cmp_state` holds exactly one set bit until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | An instruction is presented this cycle |
| cond_query | input | 3 | Condition query field: bit 2 less, bit 1 equal, bit 0 greater |
| is_compare | input | 1 | The presented instruction is a compare |
| cmp_opnd_a | input | 32 | Compare operand A (destination register value) |
| cmp_opnd_b | input | 20 | Compare operand B, raw 20-bit field, sign-extended inside |
| exec_en | output | 1 | The presented instruction may execute |
| cmp_state | output | 3 | Current comparison register value |

## Verification
The assertions assume that `rst` is held for at least one edge before any instruction arrives. They also assume that `instr_valid`, `is_compare` and the operands are stable around each rising edge. The bench keeps to this by changing every input only on the falling edge. The register-update properties take the flag-to-compare decision at face value: any cycle with `is_compare` high and `exec_en` high counts as a compare. The stimulus therefore only raises `is_compare` for instructions meant as compares.

The random phase picks operand pairs from a mix that includes equal values, sign-boundary values and values with the B sign bit set. This means all three outcomes occur often. Queries are drawn over all eight codes, with `instr_valid` deasserted in some cycles.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int CQ_W = 3;

    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
    } cq_t;

    localparam cq_t CQ_ALWAYS = '{lt: 1'b1, eq: 1'b1, gt: 1'b1};
    localparam cq_t CQ_NEVER  = '{lt: 1'b0, eq: 1'b0, gt: 1'b0};

    function automatic cq_t cq_from_bits(input logic [CQ_W-1:0] b);
        cq_t r;
        r.lt = b[2];
        r.eq = b[1];
        r.gt = b[0];
        return r;
    endfunction

    function automatic logic cq_hits(input cq_t q, input cq_t st);
        return (q.lt & st.lt) | (q.eq & st.eq) | (q.gt & st.gt);
    endfunction

endpackage

// File: rtl/pcu_sext.sv
module pcu_sext #(
    parameter int IN_W  = 20,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  narrow,
    output logic [OUT_W-1:0] wide
);
    localparam int PAD_W = OUT_W - IN_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign wide = {{PAD_W{narrow[IN_W-1]}}, narrow};
        end else begin : g_same
            assign wide = narrow[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/pcu_order.sv
module pcu_order
    import pcu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output cq_t               order
);
    logic is_less;
    logic is_equal;

    always_comb begin
        is_less  = $signed(lhs) < $signed(rhs);
        is_equal = lhs == rhs;
        order.lt = is_less;
        order.eq = is_equal;
        order.gt = ~is_less & ~is_equal;
    end
endmodule

// File: rtl/pcu_gate.sv
module pcu_gate
    import pcu_pkg::*;
(
    input  logic valid,
    input  cq_t  query,
    input  cq_t  state,
    output logic enable
);
    always_comb begin
        enable = valid & cq_hits(query, state);
    end
endmodule

// File: rtl/pcu_state_reg.sv
module pcu_state_reg
    import pcu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cq_t  next_val,
    output cq_t  cur_val
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_val <= CQ_ALWAYS;
        end else if (load) begin
            cur_val <= next_val;
        end
    end
endmodule

// File: rtl/pred_cond_unit.sv
module pred_cond_unit
    import pcu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [2:0]        cond_query,
    input  logic              is_compare,
    input  logic [DATA_W-1:0] cmp_opnd_a,
    input  logic [IMM_W-1:0]  cmp_opnd_b,
    output logic              exec_en,
    output logic [2:0]        cmp_state
);
    cq_t              query_s;
    cq_t              state_s;
    cq_t              order_s;
    logic [DATA_W-1:0] opnd_b_wide;
    logic              load_s;

    assign query_s = cq_from_bits(cond_query);

    pcu_sext #(.IN_W(IMM_W), .OUT_W(DATA_W)) u_sext (
        .narrow (cmp_opnd_b),
        .wide   (opnd_b_wide)
    );

    pcu_order #(.DATA_W(DATA_W)) u_order (
        .lhs   (cmp_opnd_a),
        .rhs   (opnd_b_wide),
        .order (order_s)
    );

    pcu_gate u_gate (
        .valid  (instr_valid),
        .query  (query_s),
        .state  (state_s),
        .enable (exec_en)
    );

    assign load_s = exec_en & is_compare;

    pcu_state_reg u_state (
        .clk      (clk),
        .rst      (rst),
        .load     (load_s),
        .next_val (order_s),
        .cur_val  (state_s)
    );

    assign cmp_state = state_s;
endmodule

// File: rtl/pred_cond_unit_chk.sv
module pred_cond_unit_chk #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              instr_valid,
    input logic [2:0]        cond_query,
    input logic              is_compare,
    input logic [DATA_W-1:0] cmp_opnd_a,
    input logic [IMM_W-1:0]  cmp_opnd_b,
    input logic              exec_en,
    input logic [2:0]        cmp_state
);
    logic              seen_cmp;
    logic              fire;
    logic [DATA_W-1:0] b_ext;

    assign fire  = instr_valid & is_compare & exec_en;
    assign b_ext = {{(DATA_W-IMM_W){cmp_opnd_b[IMM_W-1]}}, cmp_opnd_b};

    always_ff @(posedge clk) begin
        if (rst) seen_cmp <= 1'b0;
        else if (fire) seen_cmp <= 1'b1;
    end

    p_reset_value_r1: assert property (@(posedge clk)
        $past(rst) |-> cmp_state == 3'b111);

    p_exec_needs_valid_r3: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> !exec_en);

    p_never_query_r4: assert property (@(posedge clk) disable iff (rst)
        cond_query == 3'b000 |-> !exec_en);

    p_before_first_r5: assert property (@(posedge clk) disable iff (rst)
        (!seen_cmp && instr_valid && cond_query != 3'b000) |-> exec_en);

    p_less_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && $signed(cmp_opnd_a) < $signed(b_ext)) |=> cmp_state == 3'b100);

    p_equal_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && cmp_opnd_a == b_ext) |=> cmp_state == 3'b010);

    p_greater_r7: assert property (@(posedge clk) disable iff (rst)
        (fire && $signed(cmp_opnd_a) > $signed(b_ext)) |=> cmp_state == 3'b001);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(cmp_state));

    p_onehot_after_r10: assert property (@(posedge clk) disable iff (rst)
        seen_cmp |-> $countones(cmp_state) == 1);
endmodule

bind pred_cond_unit pred_cond_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .cond_query  (cond_query),
    .is_compare  (is_compare),
    .cmp_opnd_a  (cmp_opnd_a),
    .cmp_opnd_b  (cmp_opnd_b),
    .exec_en     (exec_en),
    .cmp_state   (cmp_state)
);

// File: tb/tb_pred_cond_unit.sv
`timescale 1ns/1ps
module tb_pred_cond_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [2:0]  cond_query;
    logic        is_compare;
    logic [31:0] cmp_opnd_a;
    logic [19:0] cmp_opnd_b;
    logic        exec_en;
    logic [2:0]  cmp_state;

    int n_total = 0;
    int n_fail  = 0;
    logic [2:0] model_st;
    logic       done = 1'b0;

    always #2.5 clk = ~clk;

    pred_cond_unit dut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .cond_query(cond_query),
        .is_compare(is_compare), .cmp_opnd_a(cmp_opnd_a), .cmp_opnd_b(cmp_opnd_b),
        .exec_en(exec_en), .cmp_state(cmp_state)
    );

    function automatic logic [31:0] sext20(input logic [19:0] v);
        return {{12{v[19]}}, v};
    endfunction

    function automatic logic [2:0] ref_order(input logic [31:0] a, input logic [19:0] b);
        logic [31:0] bw;
        bw = sext20(b);
        if ($signed(a) < $signed(bw)) return 3'b100;
        if (a == bw) return 3'b010;
        return 3'b001;
    endfunction

    function automatic logic ref_exec(input logic v, input logic [2:0] q, input logic [2:0] st);
        return v && ((q & st) != 3'b000);
    endfunction

    task automatic check(input logic ok, input string req, input logic [2:0] act, input logic [2:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // drive one instruction, check outputs mid-cycle, advance model at edge
    task automatic step(input logic v, input logic [2:0] q, input logic c,
                        input logic [31:0] a, input logic [19:0] b, input string req);
        logic e;
        @(negedge clk);
        instr_valid = v; cond_query = q; is_compare = c; cmp_opnd_a = a; cmp_opnd_b = b;
        #1;
        e = ref_exec(v, q, model_st);
        check(exec_en == e, req, {2'b0, exec_en}, {2'b0, e});
        check(cmp_state == model_st, req, cmp_state, model_st);
        @(posedge clk);
        if (c && e) model_st = ref_order(a, b);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; instr_valid = 1'b0; is_compare = 1'b0; cond_query = 3'b0;
        cmp_opnd_a = '0; cmp_opnd_b = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_st = 3'b111;
        #1;
        check(cmp_state == 3'b111, "R1 reset value", cmp_state, 3'b111);
    endtask

    // sweep all 8 queries against the current state, valid and invalid
    task automatic sweep(input string tag);
        for (int q = 0; q < 8; q++) begin
            step(1'b1, q[2:0], 1'b0, 32'd5, 20'd9, {tag, " R2 R4 R9 sweep"});
            step(1'b0, q[2:0], 1'b0, 32'd5, 20'd9, {tag, " R3 invalid"});
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; instr_valid = 1'b0; is_compare = 1'b0; cond_query = 3'b0;
        cmp_opnd_a = '0; cmp_opnd_b = '0;
        do_reset();

        // R5: before any compare, all nonzero queries pass
        sweep("R5 always");
        // R9: invalid compare must not update
        step(1'b0, 3'b111, 1'b1, 32'd1, 20'd7, "R9 invalid compare");
        check(cmp_state == 3'b111, "R9 state kept", cmp_state, 3'b111);

        // R6/R7: less, with B negative by sign extension vs A
        step(1'b1, 3'b111, 1'b1, 32'hFFFF_FFFE, 20'hFFFFF, "R7 signed lt");
        #1 check(cmp_state == 3'b100, "R7 -2 vs -1 lt", cmp_state, 3'b100);
        sweep("R6 lt");

        // R8: compare whose query fails must not update
        step(1'b1, 3'b011, 1'b1, 32'd100, 20'd1, "R8 failing compare");
        #1 check(cmp_state == 3'b100, "R8 state kept", cmp_state, 3'b100);
        // R9: non-compare leaves state
        step(1'b1, 3'b111, 1'b0, 32'd100, 20'd1, "R9 non-compare");
        #1 check(cmp_state == 3'b100, "R9 non-compare kept", cmp_state, 3'b100);

        // R6: equal, with sign-extended B
        step(1'b1, 3'b100, 1'b1, 32'hFFF8_0000, 20'h80000, "R7 eq sext");
        #1 check(cmp_state == 3'b010, "R7 eq with bit19 sign", cmp_state, 3'b010);
        sweep("R6 eq");

        // R7: positive A vs negative B is greater
        step(1'b1, 3'b010, 1'b1, 32'h0000_0001, 20'h80000, "R7 gt");
        #1 check(cmp_state == 3'b001, "R7 1 vs min20 gt", cmp_state, 3'b001);
        sweep("R6 gt");

        // R7: most negative A is less than anything else
        step(1'b1, 3'b001, 1'b1, 32'h8000_0000, 20'h00000, "R7 min lt");
        #1 check(cmp_state == 3'b100, "R7 min32 lt 0", cmp_state, 3'b100);

        // random phase; R10 checked through one-hot
        for (int i = 0; i < 3000; i++) begin
            logic [19:0] b;
            logic [31:0] a;
            int sel;
            b = 20'($urandom);
            sel = int'($urandom % 4);
            case (sel)
                0: a = sext20(b);
                1: a = sext20(b) + 32'd1;
                2: a = sext20(b) - 32'd1;
                default: a = $urandom;
            endcase
            step(($urandom % 5) != 0, 3'($urandom), ($urandom % 2) == 1, a, b, "R2 R6 random");
            check($countones(cmp_state) == 1, "R10 one-hot", cmp_state, model_st);
        end

        // reset again restores the always value (R1)
        do_reset();
        sweep("R1 R5 after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule